// File: doc/BRIEF.md
# Cycle-Stealing Four-Channel DMA Controller

This block moves data between peripheral registers and memory on a data bus it shares with a CPU. It has four independent channels. Each channel links a fixed peripheral register address to a memory address that advances after every move. A request comes from a software write or from a selected hardware event line. Each accepted request takes the bus away from the CPU for exactly one unit, which is either one byte or one 16-bit word. The unit is read from the source address and written to the destination address, and the bus is then handed back.

Each channel counts its moves down. When the last move of a block has been made, the count and the memory address are both restored from their reload registers and a one-cycle done pulse is raised. A mode bit decides whether the channel then disables itself or keeps serving requests. Each channel holds a single pending flag. Requests that arrive while that flag is already set are merged into it, so fewer moves than requests may take place.

Arbitration uses a fixed order, and one channel moves per bus grant. Configuration is written through a narrow port: channel number, register select and data. None of the registers can be read back.

Top module: `cs_dma_ctrl`

## Requirements
- R1: After reset, `bus_req_o`, `mem_re_o`, `mem_we_o` and `done_o` are 0, and every channel is disabled.
- R2: A pending channel raises `bus_req_o`. No memory access happens until `bus_gnt_i` is sampled high. A grant then gives exactly one read cycle followed by one write cycle, and `bus_req_o` falls afterwards if nothing is pending.
- R3: Mode bit 2 (direction) selects the transfer path. When it is 0, the read uses the peripheral address and the write uses the memory address. When it is 1, the two are swapped. The written data equals the data read.
- R4: Mode bit 1 selects a 16-bit unit when set and a byte unit when clear; `mem_word_o` shows the unit. After each move the memory address grows by 2 for a word unit or by 1 for a byte unit. The peripheral address never changes.
- R5: Among pending channels, the lowest channel number is served first. Each grant serves one channel.
- R6: A request can come from two sources: a configuration write with select 6 and data bit 0 set, or the event line `evt_i[src]` when mode bit 4 is set. Here src is mode bits 10:8. Event lines that are not selected are ignored. A channel whose enable bit (mode bit 0) is clear ignores all requests.
- R7: Requests that arrive while a request is pending, and before its grant, merge into one move. A request sampled on the grant edge or later sets the flag again and yields one more move.
- R8: The move made while the count equals 1 is the last of a block. After it, the count is restored from its reload register (select 2) and the memory address from its reload register (select 5), and `done_o[ch]` is high for one cycle.
- R9: Mode bit 3 controls what happens after the last move. When it is 0, the channel clears its enable and ignores later requests. When it is 1, the channel continues from the restored addresses.

Register selects: 0 = mode, 1 = count, 2 = count reload, 3 = memory address, 4 = peripheral address, 5 = memory address reload, 6 = software request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_req_o | output | 1 | Asks the CPU side to release the bus |
| bus_gnt_i | input | 1 | Bus released to the DMA |
| mem_re_o | output | 1 | Read strobe; data is returned on the next cycle |
| mem_we_o | output | 1 | Write strobe |
| mem_word_o | output | 1 | 1 = 16-bit unit, 0 = byte unit |
| mem_addr_o | output | RW | Byte address of the current access |
| mem_wdata_o | output | DW | Write data |
| mem_rdata_i | input | DW | Read data, one cycle after `mem_re_o` |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_ch_i | input | CHW | Channel that is written |
| cfg_sel_i | input | 3 | Register select |
| cfg_wdata_i | input | RW | Configuration data |
| evt_i | input | NSRC | Hardware request event lines |
| done_o | output | NCH | Per-channel block-complete pulse |

## Verification
Two functions of one channel can fall in the same cycle: a new request arriving, and the grant that clears the pending flag. The bench provokes this by holding a selected event line high across both the edge that sets the flag and the following grant edge. It then requires exactly two moves. As the opposite case, it holds an event high for several cycles while the grant is withheld, adds a software request on the same channel, and requires a single move. A second collision is between priority arbitration and back-to-back grants. Three channels are queued while the bus is withheld, and the order of their read addresses is judged once the grant is given.

// File: rtl/dma_ctrl_pkg.sv
package dma_ctrl_pkg;

  typedef enum logic [2:0] {
    SEL_MODE      = 3'd0,
    SEL_CNT       = 3'd1,
    SEL_CNT_RLD   = 3'd2,
    SEL_MADDR     = 3'd3,
    SEL_PADDR     = 3'd4,
    SEL_MADDR_RLD = 3'd5,
    SEL_SWREQ     = 3'd6
  } cfg_sel_e;

  localparam int MODE_EN   = 0;
  localparam int MODE_WORD = 1;
  localparam int MODE_DIR  = 2;
  localparam int MODE_KEEP = 3;
  localparam int MODE_HWEN = 4;
  localparam int MODE_SRC  = 8;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2
  } eng_st_e;

endpackage

// File: rtl/dma_chan.sv
module dma_chan
  import dma_ctrl_pkg::*;
#(
  parameter int RW   = 16,
  parameter int NSRC = 8,
  localparam int SELW = $clog2(NSRC)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cfg_we_i,
  input  logic [2:0]      cfg_sel_i,
  input  logic [RW-1:0]   cfg_wdata_i,
  input  logic [NSRC-1:0] evt_i,
  input  logic            grant_i,
  input  logic            xfer_i,
  output logic            pend_o,
  output logic            word_o,
  output logic            dir_o,
  output logic [RW-1:0]   maddr_o,
  output logic [RW-1:0]   paddr_o,
  output logic            done_o
);

  logic            en_q, word_q, dir_q, keep_q, hwen_q, pend_q, done_q;
  logic [SELW-1:0] src_q;
  logic [RW-1:0]   cnt_q, cnt_rld_q, maddr_q, mrld_q, paddr_q;
  logic            sw_hit, req_now, expire;
  logic [RW-1:0]   step;
  logic            unused_wdata;

  assign unused_wdata = ^cfg_wdata_i;
  assign sw_hit  = cfg_we_i && (cfg_sel_i == SEL_SWREQ) && cfg_wdata_i[0];
  assign req_now = en_q && (sw_hit || (hwen_q && evt_i[src_q]));
  assign expire  = (cnt_q == RW'(1));
  assign step    = word_q ? RW'(2) : RW'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q      <= 1'b0;
      word_q    <= 1'b0;
      dir_q     <= 1'b0;
      keep_q    <= 1'b0;
      hwen_q    <= 1'b0;
      src_q     <= '0;
      cnt_q     <= '0;
      cnt_rld_q <= '0;
      maddr_q   <= '0;
      mrld_q    <= '0;
      paddr_q   <= '0;
      pend_q    <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      // grant clears the flag; a request in the same cycle sets it again
      pend_q <= en_q && ((pend_q && !grant_i) || req_now);
      done_q <= xfer_i && expire;
      if (xfer_i) begin
        if (expire) begin
          cnt_q   <= cnt_rld_q;
          maddr_q <= mrld_q;
          if (!keep_q) en_q <= 1'b0;
        end else begin
          cnt_q   <= cnt_q - RW'(1);
          maddr_q <= maddr_q + step;
        end
      end
      // configuration writes win over the transfer update
      if (cfg_we_i) begin
        case (cfg_sel_i)
          SEL_MODE: begin
            en_q   <= cfg_wdata_i[MODE_EN];
            word_q <= cfg_wdata_i[MODE_WORD];
            dir_q  <= cfg_wdata_i[MODE_DIR];
            keep_q <= cfg_wdata_i[MODE_KEEP];
            hwen_q <= cfg_wdata_i[MODE_HWEN];
            src_q  <= cfg_wdata_i[MODE_SRC +: SELW];
          end
          SEL_CNT:       cnt_q     <= cfg_wdata_i;
          SEL_CNT_RLD:   cnt_rld_q <= cfg_wdata_i;
          SEL_MADDR:     maddr_q   <= cfg_wdata_i;
          SEL_PADDR:     paddr_q   <= cfg_wdata_i;
          SEL_MADDR_RLD: mrld_q    <= cfg_wdata_i;
          default: ;
        endcase
      end
    end
  end

  assign pend_o  = pend_q;
  assign word_o  = word_q;
  assign dir_o   = dir_q;
  assign maddr_o = maddr_q;
  assign paddr_o = paddr_q;
  assign done_o  = done_q;

  assert_paddr_fixed_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cfg_we_i && cfg_sel_i == SEL_PADDR) |=> $stable(paddr_q));

  assert_pend_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_i && !req_now) |=> !pend_q);

  assert_reload_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_i && expire && !cfg_we_i) |=>
      (cnt_q == $past(cnt_rld_q) && maddr_q == $past(mrld_q) && done_q));

  assert_self_disable_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_i && expire && !keep_q && !cfg_we_i) |=> !en_q);

endmodule

// File: rtl/dma_prio_arb.sv
module dma_prio_arb #(
  parameter int NCH = 4,
  localparam int CHW = $clog2(NCH)
) (
  input  logic [NCH-1:0] req_i,
  output logic           any_o,
  output logic [CHW-1:0] idx_o
);

  always_comb begin
    idx_o = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = CHW'(i);
    end
  end

  assign any_o = |req_i;

endmodule

// File: rtl/dma_bus_engine.sv
module dma_bus_engine
  import dma_ctrl_pkg::*;
#(
  parameter int NCH = 4,
  localparam int CHW = $clog2(NCH)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           bus_gnt_i,
  input  logic           any_pend_i,
  input  logic [CHW-1:0] win_idx_i,
  output logic           bus_req_o,
  output logic           rd_o,
  output logic           wr_o,
  output logic [CHW-1:0] sel_ch_o,
  output logic [NCH-1:0] grant_o,
  output logic [NCH-1:0] xfer_o
);

  eng_st_e        st_q;
  logic [CHW-1:0] sel_q;
  logic           take;

  assign take = (st_q == ST_IDLE) && any_pend_i && bus_gnt_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      sel_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (take) begin
          st_q  <= ST_READ;
          sel_q <= win_idx_i;
        end
        ST_READ:  st_q <= ST_WRITE;
        ST_WRITE: st_q <= ST_IDLE;
        default:  st_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    grant_o = '0;
    xfer_o  = '0;
    if (take) grant_o[win_idx_i] = 1'b1;
    if (st_q == ST_WRITE) xfer_o[sel_q] = 1'b1;
  end

  assign bus_req_o = (st_q != ST_IDLE) || any_pend_i;
  assign rd_o      = (st_q == ST_READ);
  assign wr_o      = (st_q == ST_WRITE);
  assign sel_ch_o  = sel_q;

  assert_steal_after_gnt_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_o |-> $past(bus_gnt_i));

  assert_read_then_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_o |=> wr_o);

  assert_single_unit_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_o |=> (!rd_o && !wr_o));

endmodule

// File: rtl/cs_dma_ctrl.sv
module cs_dma_ctrl
  import dma_ctrl_pkg::*;
#(
  parameter int NCH  = 4,
  parameter int RW   = 16,
  parameter int DW   = 16,
  parameter int NSRC = 8,
  localparam int CHW = $clog2(NCH)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  output logic            bus_req_o,
  input  logic            bus_gnt_i,
  output logic            mem_re_o,
  output logic            mem_we_o,
  output logic            mem_word_o,
  output logic [RW-1:0]   mem_addr_o,
  output logic [DW-1:0]   mem_wdata_o,
  input  logic [DW-1:0]   mem_rdata_i,
  input  logic            cfg_we_i,
  input  logic [CHW-1:0]  cfg_ch_i,
  input  logic [2:0]      cfg_sel_i,
  input  logic [RW-1:0]   cfg_wdata_i,
  input  logic [NSRC-1:0] evt_i,
  output logic [NCH-1:0]  done_o
);

  logic [NCH-1:0] pend_w, grant_w, xfer_w, word_w, dir_w;
  logic [RW-1:0]  maddr_w [NCH];
  logic [RW-1:0]  paddr_w [NCH];
  logic           any_pend, rd, wr;
  logic [CHW-1:0] win_idx, sel_ch;
  logic [RW-1:0]  src_addr, dst_addr;

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    dma_chan #(.RW(RW), .NSRC(NSRC)) i_chan (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .cfg_we_i   (cfg_we_i && (cfg_ch_i == CHW'(g))),
      .cfg_sel_i  (cfg_sel_i),
      .cfg_wdata_i(cfg_wdata_i),
      .evt_i      (evt_i),
      .grant_i    (grant_w[g]),
      .xfer_i     (xfer_w[g]),
      .pend_o     (pend_w[g]),
      .word_o     (word_w[g]),
      .dir_o      (dir_w[g]),
      .maddr_o    (maddr_w[g]),
      .paddr_o    (paddr_w[g]),
      .done_o     (done_o[g])
    );
  end

  dma_prio_arb #(.NCH(NCH)) i_arb (
    .req_i(pend_w),
    .any_o(any_pend),
    .idx_o(win_idx)
  );

  dma_bus_engine #(.NCH(NCH)) i_engine (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .bus_gnt_i (bus_gnt_i),
    .any_pend_i(any_pend),
    .win_idx_i (win_idx),
    .bus_req_o (bus_req_o),
    .rd_o      (rd),
    .wr_o      (wr),
    .sel_ch_o  (sel_ch),
    .grant_o   (grant_w),
    .xfer_o    (xfer_w)
  );

  assign src_addr    = dir_w[sel_ch] ? maddr_w[sel_ch] : paddr_w[sel_ch];
  assign dst_addr    = dir_w[sel_ch] ? paddr_w[sel_ch] : maddr_w[sel_ch];
  assign mem_addr_o  = wr ? dst_addr : src_addr;
  assign mem_re_o    = rd;
  assign mem_we_o    = wr;
  assign mem_word_o  = word_w[sel_ch];
  assign mem_wdata_o = mem_rdata_i;

  // no lower-numbered channel may be pending when a grant is issued
  assert_fixed_prio_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|grant_w) |-> ((pend_w & (grant_w - NCH'(1))) == '0));

  assert_one_grant_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant_w));

endmodule

// File: tb/test_cs_dma_ctrl.sv
`timescale 1ns/1ps
module test_cs_dma_ctrl;
  localparam int NCH = 4, RW = 16, DW = 16, NSRC = 8;

  logic clk_i = 1'b0, rst_ni = 1'b0, bus_gnt_i = 1'b1;
  logic bus_req_o, mem_re_o, mem_we_o, mem_word_o;
  logic [RW-1:0] mem_addr_o;
  logic [DW-1:0] mem_wdata_o, mem_rdata_i;
  logic cfg_we_i = 1'b0;
  logic [1:0] cfg_ch_i = '0;
  logic [2:0] cfg_sel_i = '0;
  logic [RW-1:0] cfg_wdata_i = '0;
  logic [NSRC-1:0] evt_i = '0;
  logic [NCH-1:0] done_o;

  always #2 clk_i = ~clk_i;

  cs_dma_ctrl #(.NCH(NCH), .RW(RW), .DW(DW), .NSRC(NSRC)) i_cs_dma_ctrl (.*);

  logic [7:0] mem [256];
  logic [RW-1:0] last_ra;
  logic [RW-1:0] log_ra [256];
  logic [RW-1:0] log_wa [256];
  logic [DW-1:0] log_wd [256];
  logic          log_w1 [256];
  int nlog = 0, exp_n = 0;
  int done_cnt [NCH];
  int exp_done [NCH];
  int nchk = 0, nerr = 0;

  // peripheral-side state mirror
  bit m_en [NCH], m_word [NCH], m_dir [NCH], m_keep [NCH], m_hwen [NCH], cfgd [NCH];
  int m_src [NCH];
  logic [RW-1:0] m_cnt [NCH], m_rld [NCH], m_ma [NCH], m_mrld [NCH], m_pa [NCH];

  function automatic logic [7:0] pat(input logic [7:0] a);
    return a ^ 8'h5A;
  endfunction

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = pat(8'(i));
    for (int c = 0; c < NCH; c++) begin
      done_cnt[c] = 0; exp_done[c] = 0; m_en[c] = 0; cfgd[c] = 0;
    end
  end

  always @(posedge clk_i) begin
    if (mem_re_o) begin
      mem_rdata_i <= mem_word_o ? {mem[mem_addr_o[7:0] + 8'd1], mem[mem_addr_o[7:0]]}
                                : {8'h00, mem[mem_addr_o[7:0]]};
      last_ra <= mem_addr_o;
    end
    if (mem_we_o) begin
      mem[mem_addr_o[7:0]] <= mem_wdata_o[7:0];
      if (mem_word_o) mem[mem_addr_o[7:0] + 8'd1] <= mem_wdata_o[15:8];
      log_ra[nlog] <= last_ra;
      log_wa[nlog] <= mem_addr_o;
      log_wd[nlog] <= mem_word_o ? mem_wdata_o : {8'h00, mem_wdata_o[7:0]};
      log_w1[nlog] <= mem_word_o;
      nlog <= nlog + 1;
    end
    for (int c = 0; c < NCH; c++) if (rst_ni && done_o[c]) done_cnt[c] <= done_cnt[c] + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic cfg(input int ch, input int sel, input logic [RW-1:0] d);
    cfg_we_i = 1'b1; cfg_ch_i = 2'(ch); cfg_sel_i = 3'(sel); cfg_wdata_i = d;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
  endtask

  task automatic swreq(input int ch);
    cfg(ch, 6, 16'h0001);
  endtask

  task automatic pulse_evt(input int line, input int n);
    evt_i[line] = 1'b1;
    repeat (n) @(negedge clk_i);
    evt_i[line] = 1'b0;
  endtask

  task automatic setup(input int ch, input bit word, input bit dir, input bit keep,
                       input bit hwen, input int src, input int cnt,
                       input logic [RW-1:0] ma, input logic [RW-1:0] pa);
    cfg(ch, 1, RW'(cnt)); cfg(ch, 2, RW'(cnt));
    cfg(ch, 3, ma); cfg(ch, 5, ma); cfg(ch, 4, pa);
    cfg(ch, 0, RW'(1 | (word << 1) | (dir << 2) | (keep << 3) | (hwen << 4) | (src << 8)));
    m_en[ch] = 1; m_word[ch] = word; m_dir[ch] = dir; m_keep[ch] = keep;
    m_hwen[ch] = hwen; m_src[ch] = src; cfgd[ch] = 1;
    m_cnt[ch] = RW'(cnt); m_rld[ch] = RW'(cnt); m_ma[ch] = ma; m_mrld[ch] = ma; m_pa[ch] = pa;
  endtask

  // expected effect of one move of channel ch, checked against log entry exp_n
  task automatic exp_xfer(input int ch, input string tag);
    logic [RW-1:0] src, dst;
    logic [DW-1:0] ed;
    src = m_dir[ch] ? m_ma[ch] : m_pa[ch];
    dst = m_dir[ch] ? m_pa[ch] : m_ma[ch];
    ed  = m_word[ch] ? {pat(src[7:0] + 8'd1), pat(src[7:0])} : {8'h00, pat(src[7:0])};
    chk(nlog > exp_n, {tag, " move present"}, nlog, exp_n + 1);
    chk(log_ra[exp_n] == src, {tag, " read address"}, log_ra[exp_n], src);
    chk(log_wa[exp_n] == dst, {tag, " write address"}, log_wa[exp_n], dst);
    chk(log_wd[exp_n] == ed, {tag, " data"}, log_wd[exp_n], ed);
    chk(log_w1[exp_n] == m_word[ch], {tag, " unit size"}, log_w1[exp_n], m_word[ch]);
    exp_n++;
    if (m_cnt[ch] == RW'(1)) begin
      m_cnt[ch] = m_rld[ch]; m_ma[ch] = m_mrld[ch]; exp_done[ch]++;
      if (!m_keep[ch]) m_en[ch] = 0;
    end else begin
      m_cnt[ch] = m_cnt[ch] - 1;
      m_ma[ch] = m_ma[ch] + (m_word[ch] ? 2 : 1);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk_i);
    nchk++; nerr++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin : main
    int seed;
    seed = $urandom(32'h0dac_0001);
    idle(3);
    rst_ni = 1'b1;
    idle(1);
    chk(bus_req_o == 0 && mem_re_o == 0 && mem_we_o == 0, "R1 bus idle", bus_req_o, 0);
    chk(done_o == 0, "R1 done clear", done_o, 0);
    swreq(0);
    idle(8);
    chk(nlog == 0, "R1 R6 disabled channel ignores request", nlog, 0);

    // byte, peripheral to memory
    setup(0, 0, 0, 1, 0, 0, 3, 16'h0080, 16'h0010);
    swreq(0);
    chk(bus_req_o == 1, "R2 request raised", bus_req_o, 1);
    idle(6);
    exp_xfer(0, "R3");
    chk(bus_req_o == 0, "R2 bus released", bus_req_o, 0);
    swreq(0); idle(6);
    exp_xfer(0, "R4 byte step");

    // word, memory to peripheral, self-disable
    setup(1, 1, 1, 0, 0, 0, 2, 16'h0040, 16'h0020);
    swreq(1); idle(6);
    exp_xfer(1, "R4 word");
    swreq(1); idle(3);
    chk(done_o == 4'b0010, "R8 done pulse", done_o, 4'b0010);
    idle(1);
    chk(done_o == 4'b0000, "R8 done one cycle", done_o, 0);
    idle(2);
    exp_xfer(1, "R8 last move");
    swreq(1); idle(6);
    chk(nlog == exp_n, "R9 disabled after block", nlog, exp_n);

    // keep running: last move then reload
    swreq(0); idle(6); exp_xfer(0, "R8");
    swreq(0); idle(6); exp_xfer(0, "R9 reloaded address");

    // hardware trigger on line 5
    setup(2, 0, 0, 1, 1, 5, 4, 16'h00A0, 16'h0014);
    pulse_evt(3, 1); idle(6);
    chk(nlog == exp_n, "R6 unselected line ignored", nlog, exp_n);
    pulse_evt(5, 1); idle(6);
    exp_xfer(2, "R6 event trigger");

    // priority with withheld bus
    setup(1, 0, 0, 1, 0, 0, 4, 16'h00B0, 16'h001C);
    setup(3, 0, 0, 1, 0, 0, 4, 16'h00C0, 16'h0018);
    bus_gnt_i = 1'b0;
    swreq(3); swreq(2); swreq(1);
    idle(4);
    chk(nlog == exp_n, "R2 no access without grant", nlog, exp_n);
    chk(bus_req_o == 1, "R2 request held", bus_req_o, 1);
    bus_gnt_i = 1'b1;
    idle(16);
    exp_xfer(1, "R5 first"); exp_xfer(2, "R5 second"); exp_xfer(3, "R5 third");

    // merge while pending
    bus_gnt_i = 1'b0;
    pulse_evt(5, 3); swreq(2);
    idle(2);
    bus_gnt_i = 1'b1;
    idle(10);
    exp_xfer(2, "R7 merged");
    chk(nlog == exp_n, "R7 single move for merged requests", nlog, exp_n);

    // request across the grant edge
    pulse_evt(5, 2); idle(12);
    exp_xfer(2, "R7 first");
    exp_xfer(2, "R7 regrant");
    chk(nlog == exp_n, "R7 exactly two moves", nlog, exp_n);
    for (int c = 0; c < NCH; c++)
      chk(done_cnt[c] == exp_done[c], "R8 done count", done_cnt[c], exp_done[c]);

    // random phase
    for (int c = 0; c < NCH; c++) begin
      cfg(c, 0, 16'h0000); m_en[c] = 0; cfgd[c] = 0;
    end
    for (int it = 0; it < 60; it++) begin
      int ch;
      bit w, d, hw;
      ch = int'($urandom % 4);
      if (!cfgd[ch] || ($urandom % 3) == 0) begin
        w = 1'($urandom); d = 1'($urandom); hw = 1'($urandom);
        setup(ch, w, d, 1'($urandom), hw, ch + 4 * int'($urandom % 2),
              1 + int'($urandom % 4),
              d ? RW'(16'h0040 + ($urandom % 6) * 8) : RW'(16'h0080 + ($urandom % 8) * 16),
              d ? RW'(16'h0020 + ($urandom % 16) * 2) : RW'(($urandom % 16) * 2));
      end
      if (m_hwen[ch] && ($urandom % 2)) pulse_evt(m_src[ch], 1);
      else swreq(ch);
      idle(7);
      if (m_en[ch]) exp_xfer(ch, (m_cnt[ch] == 1) ? "R8 random" : (m_word[ch] ? "R4 random" : "R3 random"));
      chk(nlog == exp_n, "R6 R9 random move count", nlog, exp_n);
      chk(done_cnt[ch] == exp_done[ch], "R8 random done count", done_cnt[ch], exp_done[ch]);
    end
    chk(bus_req_o == 0, "R2 quiet at end", bus_req_o, 0);

    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

endmodule